// File: doc/BRIEF.md
# Delta-Sigma Converter Bring-Up and Streaming Sequencer

This block sits on the host side of an SPI link to a serial delta-sigma converter. It owns the whole conversation with the converter. After reset it waits out the converter's power-up time. On a run request it sends a reset command and waits for the converter to recover. It then writes four configuration bytes and, if asked, reads them back and checks them. Finally it starts continuous conversion. From then on, every falling edge of the converter's active-low data-ready line causes one 16-bit data read, and the result appears on a sample port with a one-cycle valid strobe.

A stop request ends streaming with a power-down command and returns the block to idle. Every command uses its own chip-select frame. Each frame keeps a parameterised setup time between chip select falling and the first clock, and a hold time between the last clock and chip select rising. SPI runs in mode 1: SCLK idles low, data launch on rising edges and are captured on falling edges, most significant bit first.

Top module: `dsadc_host_seq`

## Requirements
- R1: SCLK is low whenever CS_N is high. MOSI changes only on an SCLK rising edge or when CS_N rises. MISO is captured on SCLK falling edges, MSB first.
- R2: After reset, no frame is sent for at least T_PWRUP cycles. A run request made during that time is ignored. seq_idle goes high once the wait is over.
- R3: A run request in idle first sends an 8-bit frame carrying command 0x06.
- R4: After the 0x06 frame, CS_N stays high for at least T_RST cycles before the next frame starts.
- R5: The configuration frame has 40 bits: 0x43 followed by cfg_word[31:24], [23:16], [15:8] and [7:0].
- R6: With verify_en high, a 40-bit frame follows that carries 0x23 and then 32 zero bits. The last 32 bits received must equal cfg_word. With verify_en low, this frame is skipped.
- R7: A readback mismatch sets cfg_err, which stays set until reset. The block then returns to idle without sending the 0x08 command and without producing samples.
- R8: After configuration, an 8-bit frame carrying 0x08 is sent, and streaming goes high.
- R9: While streaming, each falling edge of drdy_n produces one frame of exactly 16 SCLK rising edges with MOSI held low. The 16 received bits, MSB first, appear on sample together with a single-cycle sample_vld.
- R10: Falling edges of drdy_n outside streaming produce no frame and no sample_vld.
- R11: stop_req while streaming sends an 8-bit frame carrying 0x02 and returns the block to idle. A stop that arrives during a data read lets the read finish and deliver its sample before the 0x02 frame. A stop that reaches the block before the data-ready edge has been detected wins, and no read takes place.
- R12: In every frame, CS_N is low for at least T_SETUP cycles before the first SCLK rise. It stays low for at least T_HOLD cycles after the last SCLK fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | One-cycle request to bring up and start streaming |
| stop_req | input | 1 | One-cycle request to power the converter down |
| verify_en | input | 1 | Enables the configuration readback check |
| cfg_word | input | 32 | Four configuration bytes, register 0 in bits 31:24 |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Chip select, active low |
| sample | output | 16 | Last conversion result, two's complement |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |
| streaming | output | 1 | High while conversions are being read |
| seq_idle | output | 1 | High when waiting for a run request |
| cfg_err | output | 1 | Sticky readback-mismatch flag |

## Verification
The interesting collision is between a stop request and a data read triggered by data-ready. The bench provokes it two ways. In one, stop_req is pulsed while a read frame already has chip select low. In the other, stop_req and the data-ready fall are driven in the same input cycle, so the stop is seen before the synchronised edge. In the first case the bench expects a complete 16-clock read with its sample, followed by a 0x02 frame. In the second it expects only a 0x02 frame and no sample_vld. The frame log recorded from the pins is what decides each case.

// File: rtl/dsadc_host_seq.sv
module dsadc_host_seq #(
  parameter int CLK_DIV = 4,
  parameter int T_PWRUP = 2500,
  parameter int T_RST   = 2900,
  parameter int T_SETUP = 3,
  parameter int T_HOLD  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_req,
  input  logic        stop_req,
  input  logic        verify_en,
  input  logic [31:0] cfg_word,
  input  logic        drdy_n,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic [15:0] sample,
  output logic        sample_vld,
  output logic        streaming,
  output logic        seq_idle,
  output logic        cfg_err
);
  localparam int TW = $clog2(T_PWRUP + T_RST + T_SETUP + T_HOLD + CLK_DIV + 2);
  localparam int FW = 40;

  typedef enum logic [1:0] {PH_OFF, PH_SETUP, PH_BITS, PH_HOLD} ph_t;
  typedef enum logic [3:0] {S_PWRUP, S_IDLE, S_RST, S_RSTW, S_WREG, S_RREG,
                            S_START, S_STREAM, S_READ, S_PDN} st_t;

  ph_t ph;
  st_t st;
  logic [TW-1:0] tmr, wt;
  logic [FW-1:0] txsh, go_tx;
  logic [31:0]   rxsh;
  logic [5:0]    bitn, go_n;
  logic          go, fdone, stop_pend;
  logic [2:0]    drdy_q;
  logic          drdy_fall;

  assign drdy_fall = drdy_q[2] & ~drdy_q[1];
  assign streaming = (st == S_STREAM) || (st == S_READ);
  assign seq_idle  = (st == S_IDLE);

  // frame engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_OFF; tmr <= '0; txsh <= '0; rxsh <= '0; bitn <= '0;
      sclk <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1; fdone <= 1'b0;
    end else begin
      fdone <= 1'b0;
      case (ph)
        PH_OFF: if (go) begin
          txsh <= go_tx; bitn <= go_n; cs_n <= 1'b0; tmr <= '0; ph <= PH_SETUP;
        end
        PH_SETUP: if (tmr == TW'(T_SETUP - 1)) begin
          tmr <= '0; ph <= PH_BITS;
        end else tmr <= tmr + 1'b1;
        PH_BITS: if (tmr == TW'(CLK_DIV - 1)) begin
          tmr  <= '0;
          sclk <= ~sclk;
          if (!sclk) begin
            mosi <= txsh[FW-1];
            txsh <= txsh << 1;
          end else begin
            rxsh <= {rxsh[30:0], miso};
            bitn <= bitn - 1'b1;
            if (bitn == 6'd1) ph <= PH_HOLD;
          end
        end else tmr <= tmr + 1'b1;
        PH_HOLD: if (tmr == TW'(T_HOLD - 1)) begin
          tmr <= '0; cs_n <= 1'b1; mosi <= 1'b0; ph <= PH_OFF; fdone <= 1'b1;
        end else tmr <= tmr + 1'b1;
        default: ph <= PH_OFF;
      endcase
    end
  end

  // command script
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PWRUP; wt <= '0; go <= 1'b0; go_tx <= '0; go_n <= '0;
      sample <= '0; sample_vld <= 1'b0; cfg_err <= 1'b0; stop_pend <= 1'b0;
      drdy_q <= 3'b111;
    end else begin
      go <= 1'b0;
      sample_vld <= 1'b0;
      drdy_q <= {drdy_q[1:0], drdy_n};
      case (st)
        S_PWRUP: if (wt == TW'(T_PWRUP - 1)) st <= S_IDLE;
                 else wt <= wt + 1'b1;
        S_IDLE: if (run_req) begin
          go <= 1'b1; go_tx <= {8'h06, 32'h0}; go_n <= 6'd8; st <= S_RST;
        end
        S_RST: if (fdone) begin
          wt <= '0; st <= S_RSTW;
        end
        S_RSTW: if (wt == TW'(T_RST - 1)) begin
          go <= 1'b1; go_tx <= {8'h43, cfg_word}; go_n <= 6'd40; st <= S_WREG;
        end else wt <= wt + 1'b1;
        S_WREG: if (fdone) begin
          go <= 1'b1; go_n <= verify_en ? 6'd40 : 6'd8;
          go_tx <= verify_en ? {8'h23, 32'h0} : {8'h08, 32'h0};
          st <= verify_en ? S_RREG : S_START;
        end
        S_RREG: if (fdone) begin
          if (rxsh != cfg_word) begin
            cfg_err <= 1'b1; st <= S_IDLE;
          end else begin
            go <= 1'b1; go_tx <= {8'h08, 32'h0}; go_n <= 6'd8; st <= S_START;
          end
        end
        S_START: if (fdone) st <= S_STREAM;
        S_STREAM: if (stop_req) begin
          go <= 1'b1; go_tx <= {8'h02, 32'h0}; go_n <= 6'd8; st <= S_PDN;
        end else if (drdy_fall) begin
          go <= 1'b1; go_tx <= '0; go_n <= 6'd16; st <= S_READ;
        end
        S_READ: begin
          if (stop_req) stop_pend <= 1'b1;
          if (fdone) begin
            sample <= rxsh[15:0];
            sample_vld <= 1'b1;
            if (stop_pend || stop_req) begin
              go <= 1'b1; go_tx <= {8'h02, 32'h0}; go_n <= 6'd8;
              stop_pend <= 1'b0; st <= S_PDN;
            end else st <= S_STREAM;
          end
        end
        S_PDN: if (fdone) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sclk_low_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_mosi_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($rose(sclk) || $rose(cs_n)));
  p_quiet_pwrup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PWRUP) |-> cs_n);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  p_err_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> (st == S_IDLE));
  p_vld_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);
  p_vld_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> cs_n);
  p_no_read_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && go_n == 6'd16) |-> $past(st == S_STREAM));
endmodule

// File: tb/dsadc_host_seq_tb.sv
module dsadc_host_seq_tb;
  localparam int DIV = 2, TP = 40, TR = 30, TS = 3, TH = 4;
  localparam logic [15:0] RD_VEC [6] = '{16'h0000, 16'h7FFF, 16'h8000,
                                         16'hFFFF, 16'h1234, 16'hA5C3};
  localparam logic [31:0] CFG = 32'h0804_1000;

  logic clk = 0, rst_n = 0, run_req = 0, stop_req = 0, verify_en = 0;
  logic [31:0] cfg_word = CFG;
  logic drdy_n = 1, miso = 0;
  logic sclk, mosi, cs_n, sample_vld, streaming, seq_idle, cfg_err;
  logic [15:0] sample;

  dsadc_host_seq #(.CLK_DIV(DIV), .T_PWRUP(TP), .T_RST(TR), .T_SETUP(TS), .T_HOLD(TH)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .stop_req(stop_req),
    .verify_en(verify_en), .cfg_word(cfg_word), .drdy_n(drdy_n), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .sample(sample), .sample_vld(sample_vld),
    .streaming(streaming), .seq_idle(seq_idle), .cfg_err(cfg_err));

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  int nfr = 0, fr_n [32], fr_su [32], fr_ho [32], fr_gap [32];
  logic [63:0] fr_d [32];
  logic [39:0] slv_tx = '0, sh;
  logic pcs = 1, psclk = 0, first = 0, mval = 0;
  int nb = 0, su = 0, su_rec = 0, ho = 0, gap = 0, gap_rec = 0, mviol = 0;
  logic [63:0] dat;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // pin-level slave and frame logger, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) begin
        if (pcs) begin
          nb = 0; dat = '0; su = 0; first = 1; sh = slv_tx; gap_rec = gap;
        end
        if (sclk && !psclk) begin
          if (first) begin su_rec = su; first = 0; end
          nb++; mval = mosi; miso = sh[39]; sh = sh << 1;
        end
        if (!sclk && psclk) begin
          if (mosi !== mval) mviol++;
          dat = {dat[62:0], mosi}; ho = 0;
        end
        if (first) su++;
        ho++;
      end else begin
        if (!pcs && nfr < 32) begin
          fr_n[nfr] = nb; fr_d[nfr] = dat; fr_su[nfr] = su_rec;
          fr_ho[nfr] = ho; fr_gap[nfr] = gap_rec; nfr++; gap = 0;
        end
        if (sclk) mviol++;
        gap++;
      end
      pcs = cs_n; psclk = sclk;
    end
  end

  task automatic pulse_run();
    @(negedge clk) run_req = 1;
    @(negedge clk) run_req = 0;
  endtask

  task automatic wait_state(input bit want_stream);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (want_stream ? streaming : seq_idle) break;
    end
  endtask

  task automatic timing_ok(input int i, input string tag);
    chk({tag, " R12 setup"}, 64'(fr_su[i] >= TS), 64'd1);
    chk({tag, " R12 hold"}, 64'(fr_ho[i] >= TH), 64'd1);
  endtask

  task automatic do_read(input logic [15:0] v, input string tag);
    int n0, vc;
    logic [15:0] got;
    n0 = nfr; vc = 0; got = 'x;
    slv_tx = {v, 24'h0};
    @(negedge clk) drdy_n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (i == 4) drdy_n = 1;
      if (sample_vld) begin vc++; got = sample; end
    end
    chk({tag, " R9 vld count"}, 64'(vc), 64'd1);
    chk({tag, " R9 sample"}, 64'(got), 64'(v));
    chk({tag, " R9 frames"}, 64'(nfr - n0), 64'd1);
    chk({tag, " R9 bits"}, 64'(fr_n[n0]), 64'd16);
    chk({tag, " R9 mosi low"}, fr_d[n0][15:0], 64'd0);
    timing_ok(n0, tag);
  endtask

  initial begin
    int pc, n0, vc;
    // reset state and power-up wait
    repeat (3) @(negedge clk);
    chk("R2 reset cs_n", 64'(cs_n), 64'd1);
    chk("R1 reset sclk", 64'(sclk), 64'd0);
    chk("R9 reset vld", 64'(sample_vld), 64'd0);
    chk("R7 reset err", 64'(cfg_err), 64'd0);
    rst_n = 1;
    pc = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      pc++;
      if (i == 5) run_req = 1;
      if (i == 6) run_req = 0;
      if (seq_idle) break;
    end
    chk("R2 wait length", 64'(pc >= TP), 64'd1);
    repeat (100) @(negedge clk);
    chk("R2 early run ignored", 64'(nfr), 64'd0);

    // bring-up with readback
    verify_en = 1; slv_tx = {8'h5A, CFG};
    pulse_run();
    wait_state(1);
    chk("R8 streaming", 64'(streaming), 64'd1);
    chk("R3 frame0 bits", 64'(fr_n[0]), 64'd8);
    chk("R3 frame0 cmd", fr_d[0][7:0], 64'h06);
    chk("R4 reset gap", 64'(fr_gap[1] >= TR), 64'd1);
    chk("R5 cfg bits", 64'(fr_n[1]), 64'd40);
    chk("R5 cfg data", fr_d[1][39:0], {24'h0, 8'h43, CFG});
    chk("R6 rb bits", 64'(fr_n[2]), 64'd40);
    chk("R6 rb data", fr_d[2][39:0], {24'h0, 8'h23, 32'h0});
    chk("R8 start cmd", {56'h0, fr_d[3][7:0]}, 64'h08);
    chk("R8 start bits", 64'(fr_n[3]), 64'd8);
    chk("R7 no err", 64'(cfg_err), 64'd0);
    for (int i = 0; i < 4; i++) timing_ok(i, "bringup");

    // streaming reads walked from the vector table
    foreach (RD_VEC[k]) do_read(RD_VEC[k], $sformatf("vec%0d", k));

    // plain stop
    n0 = nfr;
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
    repeat (200) @(negedge clk);
    chk("R11 stop frames", 64'(nfr - n0), 64'd1);
    chk("R11 pdn cmd", fr_d[n0][7:0], 64'h02);
    chk("R11 idle", 64'(seq_idle), 64'd1);
    chk("R11 not streaming", 64'(streaming), 64'd0);

    // data-ready in idle is ignored
    n0 = nfr; vc = 0;
    @(negedge clk) drdy_n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i == 4) drdy_n = 1;
      if (sample_vld) vc++;
    end
    chk("R10 no frame", 64'(nfr - n0), 64'd0);
    chk("R10 no vld", 64'(vc), 64'd0);

    // bring-up without readback
    verify_en = 0; n0 = nfr;
    pulse_run();
    wait_state(1);
    chk("R6 skip frames", 64'(nfr - n0), 64'd3);
    chk("R6 skip start", fr_d[n0 + 2][7:0], 64'h08);

    // stop arrives during an active read
    n0 = nfr; vc = 0; slv_tx = {16'hC0DE, 24'h0};
    @(negedge clk) drdy_n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i == 4) drdy_n = 1;
      if (!cs_n) break;
    end
    @(negedge clk) stop_req = 1;
    @(negedge clk) stop_req = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sample_vld) begin vc++; chk("R11 deferred sample", 64'(sample), 64'hC0DE); end
    end
    drdy_n = 1;
    chk("R11 deferred vld", 64'(vc), 64'd1);
    chk("R11 deferred frames", 64'(nfr - n0), 64'd2);
    chk("R11 read then pdn", {fr_n[n0][7:0], fr_d[n0 + 1][7:0]}, {8'd16, 8'h02});
    chk("R11 deferred idle", 64'(seq_idle), 64'd1);

    // stop and data-ready in the same input cycle
    pulse_run();
    wait_state(1);
    n0 = nfr; vc = 0;
    @(negedge clk) begin drdy_n = 0; stop_req = 1; end
    @(negedge clk) stop_req = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i == 4) drdy_n = 1;
      if (sample_vld) vc++;
    end
    chk("R11 collide frames", 64'(nfr - n0), 64'd1);
    chk("R11 collide cmd", fr_d[n0][7:0], 64'h02);
    chk("R11 collide no vld", 64'(vc), 64'd0);

    // readback mismatch
    verify_en = 1; slv_tx = {8'h00, CFG ^ 32'h0000_0100}; n0 = nfr;
    pulse_run();
    wait_state(0);
    repeat (300) @(negedge clk);
    chk("R7 err set", 64'(cfg_err), 64'd1);
    chk("R7 frames", 64'(nfr - n0), 64'd3);
    chk("R7 last is readback", fr_d[n0 + 2][39:32], 64'h23);
    chk("R7 idle", 64'(seq_idle), 64'd1);
    chk("R7 not streaming", 64'(streaming), 64'd0);

    chk("R1 mosi stable while sclk high", 64'(mviol), 64'd0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule